// File: doc/BRIEF.md
# Board Interrupt Status Aggregator

This block gathers five board-level interrupt lines into a single level-sensitive request to the CPU. Each line passes through a two-stage synchronizer. Lines 2 and 4 are active-low and lines 0, 1 and 3 are active-high, so the block flips the two low-true lines to form a normalized pending view. That view is then gated by a byte-wide enable register in which a 1 blocks its source and a 0 lets it through. Software masks a source by setting its bit and unmasks it by clearing it, using a read-modify-write of that one byte.

Three registers sit on a small read/write bus:

| Address | Register | Access | Contents |
|---------|----------|--------|----------|
| 0 | Status | read-only | Synchronized raw input levels, before normalization |
| 1 | Enable | read/write | One inverted-sense enable bit per source |
| 2 | Index | read-only | Number of the lowest pending source plus one, or 0 when nothing is pending |

The index register lets a handler pick its source without a bit scan.

The read path is a two-state machine. In RD_IDLE no response is driven. The transition RD_IDLE→RD_RESP happens on any cycle with the read strobe high. The transition RD_RESP→RD_IDLE happens on a cycle with no read strobe. RD_RESP→RD_RESP happens on back-to-back reads. In RD_RESP the data captured at the strobe is presented together with the valid flag.

Top module: `board_irq_combiner`

## Requirements
- R1: After reset the enable register reads 0x1F, so every source is blocked, and `cpu_irq` and `bus_rvalid` are low.
- R2: Enable bit n (n = 0..4) set to 0 lets source n through and set to 1 blocks it. A write to address 1 stores bits 4:0 only, and bits 7:5 always read back as 0.
- R3: Normalized status is the synchronized raw status XOR 0x14. Source 2 and source 4 are pending when their input is low. Sources 0, 1 and 3 are pending when their input is high.
- R4: `cpu_irq` is high exactly when (normalized status AND NOT enable AND 0x1F) is nonzero. It is registered:
  - it follows an enable write one cycle after the write edge;
  - it follows a raw input change three clock edges after the change (two synchronizer stages plus the output register).
- R5: A read of address 2 returns in bits 2:0 the number of the lowest-numbered pending source plus one (values 1..5), or 0 when no source is pending. Bits 7:3 read 0. The lowest-numbered source wins when several are pending.
- R6: A read of address 0 returns the raw input levels, not normalized, after two flip-flops, in bits 4:0 with bits 7:5 at 0. Writes to address 0 change neither the status read-back nor `cpu_irq`.
- R7: A read strobe samples the address and raises `bus_rvalid` with the data in the next cycle only. Address 3 reads 0. A cycle with no read strobe leaves `bus_rvalid` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | 5 | Raw interrupt levels from the board sources |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The assertions assume three things about the inputs:
- The bus strobes are low while reset is asserted, so the first post-reset sample of `bus_rd` is a real idle.
- The read address is held stable in the strobe cycle.
- Reads never overlap with the response of a previous read to a different register.

The stimulus meets these conditions by driving every strobe and address on the falling edge and keeping each strobe high for exactly one cycle. It also changes `src_lvl` only on falling edges and then waits at least four cycles before sampling, so no check falls inside the synchronizer latency. The one exception is the directed latency test, which samples each intermediate edge on purpose.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned SRC_COUNT = 5;
    localparam int unsigned BUS_DW    = 8;
    localparam int unsigned BUS_AW    = 2;

    localparam logic [BUS_AW-1:0] ADDR_STATUS = 2'd0;
    localparam logic [BUS_AW-1:0] ADDR_ENABLE = 2'd1;
    localparam logic [BUS_AW-1:0] ADDR_INDEX  = 2'd2;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_in;
            stage2_q <= stage1_q;
        end
    end

    assign q_out = stage2_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned N     = 5,
    parameter int unsigned IDX_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     pend,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit overrides last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDX_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned N      = SRC_COUNT,
    parameter int unsigned DATA_W = BUS_DW,
    parameter int unsigned IDX_W  = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N-1:0]      stat_sync,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [N-1:0]      en_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[DATA_W-1:N];

    // Enable register: inverted sense, starts with every source blocked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '1;
        end else if (bus_wr && (bus_addr == ADDR_ENABLE)) begin
            en_q <= bus_wdata[N-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata_d = '0;
        case (bus_addr)
            ADDR_STATUS: rdata_d[N-1:0]     = stat_sync;
            ADDR_ENABLE: rdata_d[N-1:0]     = en_q;
            ADDR_INDEX:  rdata_d[IDX_W-1:0] = win_idx;
            default:     rdata_d            = '0;
        endcase
    end

    // Next-state logic for the read response.
    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = bus_rd ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = bus_rd ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    // State register and read data capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (bus_rd) begin
                rdata_q <= rdata_d;
            end
        end
    end

    // Outputs.
    always_comb begin
        bus_rvalid = (state_q == RD_RESP);
        bus_rdata  = bus_rvalid ? rdata_q : '0;
    end
endmodule

// File: rtl/board_irq_combiner.sv
module board_irq_combiner
    import irqagg_pkg::*;
#(
    parameter int unsigned    NUM_SRC = SRC_COUNT,
    parameter int unsigned    DATA_W  = BUS_DW,
    parameter logic [NUM_SRC-1:0] ACT_LOW = 5'h14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    output logic               cpu_irq
);
    localparam int unsigned IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend;
    logic [IDX_W-1:0]   win_idx;

    irq_sync #(.W(NUM_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (src_lvl),
        .q_out (src_sync)
    );

    // Normalize polarity, then gate with the inverted-sense enables.
    assign pend = (src_sync ^ ACT_LOW) & ~en_q;

    irq_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc (
        .pend (pend),
        .idx  (win_idx)
    );

    irq_bus_regs #(.N(NUM_SRC), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .stat_sync  (src_sync),
        .win_idx    (win_idx),
        .en_q       (en_q),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_irq <= 1'b0;
        end else begin
            cpu_irq <= |pend;
        end
    end
endmodule

// File: rtl/board_irq_combiner_chk.sv
module board_irq_combiner_chk
    import irqagg_pkg::*;
#(
    parameter int unsigned N      = SRC_COUNT,
    parameter int unsigned DATA_W = BUS_DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_rvalid,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cpu_irq,
    input logic [N-1:0]      en_q
);
    // R7
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R7
    rd_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R5
    idx_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_addr) == ADDR_INDEX) |-> (bus_rdata[DATA_W-1:3] == '0));

    // R6
    stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_addr) == ADDR_STATUS) |-> (bus_rdata[DATA_W-1:N] == '0));

    // R2
    en_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_addr) == ADDR_ENABLE) |-> (bus_rdata[DATA_W-1:N] == '0));

    // R4
    all_blocked_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '1) |=> !cpu_irq);
endmodule

bind board_irq_combiner board_irq_combiner_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .cpu_irq    (cpu_irq),
    .en_q       (en_q)
);

// File: tb/test_board_irq_combiner.sv
module test_board_irq_combiner;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // {raw[4:0], enable[4:0], irq, index[2:0]}
    localparam logic [13:0] VEC [NV] = '{
        {5'b10100, 5'b00000, 1'b0, 3'd0},
        {5'b00000, 5'b00000, 1'b1, 3'd3},
        {5'b00000, 5'b00100, 1'b1, 3'd5},
        {5'b00000, 5'b10100, 1'b0, 3'd0},
        {5'b10111, 5'b00000, 1'b1, 3'd1},
        {5'b10111, 5'b00001, 1'b1, 3'd2},
        {5'b11100, 5'b00000, 1'b1, 3'd4},
        {5'b11111, 5'b11111, 1'b0, 3'd0},
        {5'b11111, 5'b11110, 1'b1, 3'd1},
        {5'b01111, 5'b01011, 1'b1, 3'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_lvl = 5'b10100;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic       cpu_irq;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    board_irq_combiner i_board_irq_combiner (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        check("R7 rvalid with data", {7'd0, bus_rvalid}, 8'd1);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq in reset", {7'd0, cpu_irq}, 8'd0);
        check("R1 rvalid in reset", {7'd0, bus_rvalid}, 8'd0);
        rst_n = 1'b1;
        settle();
        check("R1 irq after reset", {7'd0, cpu_irq}, 8'd0);
        bus_read(2'd1, rd);
        check("R1 enable reset value", rd, 8'h1F);
        @(negedge clk);
        check("R7 rvalid one cycle", {7'd0, bus_rvalid}, 8'd0);

        // Vector table: R2 R3 R4 R5 R6
        for (int k = 0; k < NV; k++) begin
            src_lvl = VEC[k][13:9];
            bus_write(2'd1, {3'b000, VEC[k][8:4]});
            settle();
            check("R4 irq level (R3 polarity)", {7'd0, cpu_irq}, {7'd0, VEC[k][3]});
            bus_read(2'd2, rd);
            check("R5 index", rd, {5'd0, VEC[k][2:0]});
            bus_read(2'd0, rd);
            check("R6 status raw", rd, {3'd0, VEC[k][13:9]});
            bus_read(2'd1, rd);
            check("R2 enable readback", rd, {3'd0, VEC[k][8:4]});
        end

        // R6 writes to status ignored
        src_lvl = 5'b10111;
        bus_write(2'd1, 8'h00);
        settle();
        bus_write(2'd0, 8'hFF);
        settle();
        bus_read(2'd0, rd);
        check("R6 status write ignored", rd, 8'h17);
        check("R6 irq after status write", {7'd0, cpu_irq}, 8'd1);

        // R2 upper enable bits not stored
        bus_write(2'd1, 8'hFF);
        bus_write(2'd1, 8'hE0);
        bus_read(2'd1, rd);
        check("R2 upper bits dropped", rd, 8'h00);

        // R7 unmapped address
        bus_read(2'd3, rd);
        check("R7 address 3 reads zero", rd, 8'h00);

        // R4 enable-write latency with read-modify-write masking
        src_lvl = 5'b00000;
        settle();
        check("R4 irq before mask", {7'd0, cpu_irq}, 8'd1);
        bus_read(2'd1, rd);
        bus_write(2'd1, rd | 8'h14);
        check("R4 irq one cycle after write old", {7'd0, cpu_irq}, 8'd1);
        @(negedge clk);
        check("R4 irq masked next cycle", {7'd0, cpu_irq}, 8'd0);

        // R4 input latency through synchronizer
        bus_write(2'd1, 8'h00);
        src_lvl = 5'b10100;
        settle();
        check("R3 all inactive", {7'd0, cpu_irq}, 8'd0);
        src_lvl = 5'b10101;
        @(negedge clk);
        @(negedge clk);
        check("R4 irq still low after two edges", {7'd0, cpu_irq}, 8'd0);
        @(negedge clk);
        check("R4 irq high after three edges", {7'd0, cpu_irq}, 8'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule